// File: doc/BRIEF.md
# Keyboard Interrupt Detection Controller

The controller watches a row of keypad input lines and raises one interrupt request when any selected line becomes active. Each line can be switched into the watch set on its own, and each has its own sense: active-low (falling transition or low level) or active-high (rising transition or high level). The raw lines are brought into the clock domain through a two-stage synchronizer before any detection is done.

All lines feed one sticky event flag. How the flag is cleared depends on the detection mode. In transition-only mode, writing a one to the acknowledge position clears it. In transition-plus-level mode, it cannot be cleared while any watched line is still held at its active level. The interrupt output is the flag gated by an enable bit. Software drives the block through a small register port with a combinational read path.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Address 0 is the control word. Bit 3 is the event flag and is read-only. Bit 2 is the acknowledge and always reads 0. Bit 1 is the interrupt enable. Bit 0 selects the mode: 0 for transitions only, 1 for transitions plus levels. Bits 7..4 read 0. A write to bit 3 does not change the flag.
- R3: Address 1 holds the per-line watch mask (bit n for line n). Address 2 holds the per-line sense (1 for active-high, 0 for active-low). Both read back what was written. Address 3 reads 0.
- R4: A watched line that passes from its inactive to its active value sets the flag. The flag becomes visible on the third rising clock edge after the line changes.
- R5: Activity on a line whose watch bit is 0 never sets the flag.
- R6: In transition-only mode, a write of 1 to bit 2 of address 0 clears the flag, even while the line is still held active.
- R7: In transition-plus-level mode, the flag stays set while any watched line is at its active level. An acknowledge clears it once no watched line is active.
- R8: The flag sets regardless of the interrupt enable. `irq_o` is high exactly when both the flag and the enable are set.
- R9: When an acknowledge and a new detection fall in the same cycle, the flag stays set.
- R10: In transition-only mode, a watched line going from active back to inactive does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | 8 | Asynchronous keypad lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the write strobe, address and write data are stable around each rising edge. They also assume that the keypad lines are sampled only through the synchronizer, so any detection reaches the flag one register after the detector's combined hit. The stimulus changes lines and register inputs only at falling edges. It holds every line level for at least three cycles before judging the flag, so each transition passes the synchronizer cleanly before it is counted.

// File: rtl/kbd_irq_pkg.sv
package kbd_irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTL  = 2'd0,
    ADR_MASK = 2'd1,
    ADR_SENS = 2'd2,
    ADR_NONE = 2'd3
  } kbd_addr_e;

  localparam int unsigned CTL_FLAG = 3;
  localparam int unsigned CTL_ACK  = 2;
  localparam int unsigned CTL_IE   = 1;
  localparam int unsigned CTL_MODE = 0;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_detect.sv
module kbd_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_s,
  input  logic [WIDTH-1:0] watch,
  input  logic [WIDTH-1:0] sense,
  input  logic             level_mode,
  output logic             set_any,
  output logic             level_any
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;
  logic [WIDTH-1:0] act_now;
  logic [WIDTH-1:0] act_prev;
  logic [WIDTH-1:0] edge_hit;
  logic [WIDTH-1:0] lvl_hit;

  always_comb prev_d = line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      assign act_now[g]  = sense[g] ? line_s[g] : ~line_s[g];
      assign act_prev[g] = sense[g] ? prev_q[g] : ~prev_q[g];
      assign edge_hit[g] = watch[g] & act_now[g] & ~act_prev[g];
      assign lvl_hit[g]  = watch[g] & act_now[g];
    end
  endgenerate

  assign level_any = |lvl_hit;
  assign set_any   = (|edge_hit) | (level_mode & level_any);
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              set_any,
  output logic [WIDTH-1:0]  watch_q,
  output logic [WIDTH-1:0]  sense_q,
  output logic              ie_q,
  output logic              mode_q,
  output logic              flag_q
);
  logic             ctl_wr, mask_wr, sens_wr, ack;
  logic [WIDTH-1:0] watch_d, sense_d;
  logic             ie_d, mode_d, flag_d;

  always_comb begin
    ctl_wr  = reg_we && (reg_addr == ADR_CTL);
    mask_wr = reg_we && (reg_addr == ADR_MASK);
    sens_wr = reg_we && (reg_addr == ADR_SENS);
    ack     = ctl_wr && reg_wdata[CTL_ACK];

    ie_d    = ctl_wr  ? reg_wdata[CTL_IE]   : ie_q;
    mode_d  = ctl_wr  ? reg_wdata[CTL_MODE] : mode_q;
    watch_d = mask_wr ? reg_wdata[WIDTH-1:0] : watch_q;
    sense_d = sens_wr ? reg_wdata[WIDTH-1:0] : sense_q;

    if (set_any)  flag_d = 1'b1;
    else if (ack) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      mode_q  <= 1'b0;
      watch_q <= '0;
      sense_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      ie_q    <= ie_d;
      mode_q  <= mode_d;
      watch_q <= watch_d;
      sense_q <= sense_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_CTL: begin
        reg_rdata[CTL_FLAG] = flag_q;
        reg_rdata[CTL_IE]   = ie_q;
        reg_rdata[CTL_MODE] = mode_q;
      end
      ADR_MASK: reg_rdata[WIDTH-1:0] = watch_q;
      ADR_SENS: reg_rdata[WIDTH-1:0] = sense_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
  import kbd_irq_pkg::*;
#(
  parameter int unsigned NLINES      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pins_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic              rst_sync_n;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] watch_q, sense_q;
  logic              ie_q, mode_q, flag_q;
  logic              set_any, level_any;

  kbd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kbd_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pins_i),
    .sync_o  (line_s)
  );

  kbd_detect #(.WIDTH(NLINES)) u_det (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_s     (line_s),
    .watch      (watch_q),
    .sense      (sense_q),
    .level_mode (mode_q),
    .set_any    (set_any),
    .level_any  (level_any)
  );

  kbd_regs #(.WIDTH(NLINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .set_any   (set_any),
    .watch_q   (watch_q),
    .sense_q   (sense_q),
    .ie_q      (ie_q),
    .mode_q    (mode_q),
    .flag_q    (flag_q)
  );

  assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/kbd_irq_chk.sv
module kbd_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_o,
  input logic       flag,
  input logic       ie,
  input logic       mode,
  input logic       set_any,
  input logic       level_any
);
  a_r8_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag && ie));

  a_r8_irq_when_both: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ie) |-> irq_o);

  a_r9_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> flag);

  a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && level_any) |=> flag);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && reg_wdata[2] && !set_any) |=> !flag);

  a_r5_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_any));

  a_r2_ctl_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7:4] == 4'd0 && !reg_rdata[2]));
endmodule

bind kbd_irq_ctrl kbd_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .flag      (flag_q),
  .ie        (ie_q),
  .mode      (mode_q),
  .set_any   (set_any),
  .level_any (level_any)
);

// File: tb/sim_kbd_irq_ctrl.sv
module sim_kbd_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pins;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_irq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (pins),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic flag_is(input string tag, input logic exp);
    logic [7:0] v;
    rd(2'd0, v);
    chk(tag, {7'd0, v[3]}, {7'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; pins = 8'hFF; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    tick(3);
    // R1: reset state
    rd(2'd0, v); chk("R1 ctl", v, 8'h00);
    rd(2'd1, v); chk("R1 mask", v, 8'h00);
    rd(2'd2, v); chk("R1 sense", v, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    tick(4);

    // R2: control word layout, flag read-only, ack reads 0
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 ctl readback", v, 8'h03);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R2 ctl cleared", v, 8'h00);
    // R3: mask, sense, empty address
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R3 mask", v, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, v); chk("R3 sense", v, 8'h3C);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R3 empty", v, 8'h00);
    rd(2'd1, v); chk("R3 mask kept", v, 8'hA5);

    // sweep: mode x sense x line
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 8; i++) begin
          automatic logic [7:0] sens = p ? 8'hFF : 8'h00;
          automatic logic [7:0] idle = ~sens;
          automatic int j = (i + 1) % 8;
          wr(2'd1, 8'h00);
          wr(2'd2, sens);
          pins = idle;
          tick(4);
          wr(2'd1, 8'h01 << i);
          wr(2'd0, 8'h06 | m[7:0]);
          tick(1);
          flag_is("R4 baseline", 1'b0);
          // R5: unwatched line
          pins[j] = ~pins[j];
          tick(4);
          flag_is("R5 unwatched", 1'b0);
          pins[j] = ~pins[j];
          tick(4);
          // R4: watched line, latency of three edges
          pins[i] = ~pins[i];
          tick(2);
          flag_is("R4 not yet", 1'b0);
          tick(1);
          flag_is("R4 set", 1'b1);
          chk("R8 irq on", {7'd0, irq_o}, 8'h01);
          // R6 / R7: acknowledge while held
          wr(2'd0, 8'h06 | m[7:0]);
          flag_is(m ? "R7 held" : "R6 cleared", m ? 1'b1 : 1'b0);
          // release
          pins[i] = ~pins[i];
          tick(3);
          if (m == 0) flag_is("R10 release", 1'b0);
          wr(2'd0, 8'h06 | m[7:0]);
          flag_is("R7 released ack", 1'b0);
        end
      end
    end

    // R8: flag without enable
    wr(2'd1, 8'h01); wr(2'd2, 8'h01); pins = 8'h00; tick(4);
    wr(2'd0, 8'h04); tick(1);
    pins[0] = 1'b1; tick(3);
    flag_is("R8 flag no ie", 1'b1);
    chk("R8 irq off", {7'd0, irq_o}, 8'h00);
    wr(2'd0, 8'h02);
    chk("R8 irq after ie", {7'd0, irq_o}, 8'h01);
    // R9: ack in the detection cycle
    wr(2'd0, 8'h06); pins = 8'h00; tick(4);
    flag_is("R9 prep", 1'b0);
    pins[0] = 1'b1; tick(2);
    wr(2'd0, 8'h06);
    flag_is("R9 detect wins", 1'b1);
    wr(2'd0, 8'h06);
    flag_is("R9 later ack", 1'b0);
    // R7: level mode with line already active when enabled
    wr(2'd0, 8'h03); tick(1);
    flag_is("R7 level sets", 1'b1);
    wr(2'd0, 8'h07); tick(2);
    flag_is("R7 level resets", 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule